// File: doc/BRIEF.md
# Double-to-Single Store Narrowing Converter

This block sits in front of the single-precision store path. It takes a 64-bit double-precision register image and produces the 32-bit single-precision word that gets written to memory. Each input beat is qualified by `in_valid`. The converted word appears on `out_word` one clock later, with `out_valid` high. Bit numbering in the requirements is big-endian: bit 0 is the most significant bit. In the SystemVerilog vectors, big-endian bit *i* is vector bit 63−*i* (input) or 31−*i* (output).

Every beat is sorted into one of three conversion paths by its 11-bit biased exponent *E* (big-endian bits 1..11):

- **DIRECT**: *E* ≥ 897, or the whole magnitude (bits 1..63) is zero. Fields are copied straight across. This covers normal values, signed zeros, infinities and NaNs.
- **SUBNORM**: 874 ≤ *E* ≤ 896. The hidden-one significand is shifted right by 897−*E* places to build a single-precision denormal.
- **FLUSH**: any other nonzero value. The result is all zeros.

Nothing is rounded; bits that fall off the right end are simply dropped. The path decision and the shift happen in the same cycle. The only state is the output register, which loads on a valid beat and otherwise holds its value.

Top module: `d2s_narrow`

## Requirements
- R1: For a DIRECT beat with E ≥ 897, output bit 0 is input bit 0, output bit 1 is input bit 1, and output bits 2..31 are input bits 5..34.
- R2: A zero magnitude (input bits 1..63 all zero) takes the DIRECT path, so +0 gives 0x00000000 and −0 gives 0x80000000.
- R3: For a SUBNORM beat (874 ≤ E ≤ 896):
  - output bit 0 is the input sign and output bits 1..8 are zero;
  - form the 53-bit significand as a 1 followed by input bits 12..63;
  - shift it right by 897−E with zero fill;
  - output bits 9..31 are bits 1..23 of the shifted significand.
- R4: At the window edges, E = 896 gives output bit 9 set (fraction MSB = 1). E = 874 gives a fraction field of exactly 1.
- R5: A nonzero value with E < 874 produces 0x00000000. This includes double-precision denormals (E = 0) and E = 873.
- R6: There is no rounding. Input bits 35..63 never affect the result, except through the zero-magnitude test.
- R7: Infinities and NaNs (E = 2047) pass through the DIRECT path. A NaN whose payload lies only in bits 35..63 therefore becomes an infinity pattern.
- R8: `out_valid` is high exactly one cycle after a cycle with `in_valid` high, and low otherwise.
- R9: While `in_valid` is low, `out_word` keeps its previous value.
- R10: Synchronous reset clears `out_valid` and `out_word` to zero, and takes priority over a simultaneous `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat qualifier |
| in_dword | input | 64 | Double-precision input value |
| out_valid | output | 1 | Result qualifier, one cycle after in_valid |
| out_word | output | 32 | Single-precision result |

## Verification
Two functions can land on the same clock edge:

- Reset and the load of a fresh conversion. The bench drives `in_valid` with a valid SUBNORM operand while `rst` is high. It then expects zeros on both outputs, not the converted word.
- The hold behaviour and a dropped-bit change. Back-to-back beats that differ only in bits 35..63 must leave `out_word` unchanged, and the bench judges this against its behavioural model, which shifts one bit at a time until the exponent reaches −126.

Boundary exponents 873, 874, 896 and 897 are driven directly, as are signed zeros, infinities and NaNs.

// File: rtl/d2s_pkg.sv
package d2s_pkg;

    localparam int DBL_W      = 64;
    localparam int DBL_EXP_W  = 11;
    localparam int DBL_FRAC_W = 52;
    localparam int DBL_BIAS   = 1023;

    localparam int SGL_W      = 32;
    localparam int SGL_EXP_W  = 8;
    localparam int SGL_FRAC_W = 23;
    localparam int SGL_BIAS   = 127;

    // smallest double exponent that maps onto a normal single
    localparam int DIRECT_MIN_EXP = DBL_BIAS - SGL_BIAS + 1;
    // smallest double exponent that still leaves the hidden one in the fraction
    localparam int SUB_MIN_EXP    = DIRECT_MIN_EXP - SGL_FRAC_W;
    // shift amounts 1..SGL_FRAC_W
    localparam int SHAMT_W        = $clog2(SGL_FRAC_W + 1);
    // hidden one plus the kept fraction bits
    localparam int KEEP_W         = SGL_FRAC_W + 1;
    // low fraction bits that never reach the result
    localparam int DROP_W         = DBL_FRAC_W - SGL_FRAC_W;
    // exponent bits of the double that are skipped on the direct path
    localparam int EXP_SKIP_W     = DBL_EXP_W - SGL_EXP_W;

    typedef enum logic [1:0] {
        PATH_DIRECT  = 2'd0,
        PATH_SUBNORM = 2'd1,
        PATH_FLUSH   = 2'd2
    } path_e;

endpackage

// File: rtl/d2s_classify.sv
module d2s_classify
    import d2s_pkg::*;
(
    input  logic [DBL_EXP_W-1:0] exp_i,
    input  logic                 mag_zero_i,
    output path_e                path_o,
    output logic [SHAMT_W-1:0]   shamt_o
);

    always_comb begin
        if (mag_zero_i || (int'(exp_i) >= DIRECT_MIN_EXP)) begin
            path_o = PATH_DIRECT;
        end else if (int'(exp_i) >= SUB_MIN_EXP) begin
            path_o = PATH_SUBNORM;
        end else begin
            path_o = PATH_FLUSH;
        end
    end

    // distance to the first normal exponent; only the low bits matter
    // because the window is narrower than 2**SHAMT_W
    assign shamt_o = SHAMT_W'(DIRECT_MIN_EXP) - exp_i[SHAMT_W-1:0];

endmodule

// File: rtl/d2s_denorm_shift.sv
module d2s_denorm_shift
    import d2s_pkg::*;
(
    input  logic [KEEP_W-1:0]  sig_i,
    input  logic [SHAMT_W-1:0] amt_i,
    output logic [KEEP_W-1:0]  sig_o
);

    logic [KEEP_W-1:0] stage [SHAMT_W+1];

    assign stage[0] = sig_i;

    for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
        assign stage[k+1] = amt_i[k] ? (stage[k] >> (1 << k)) : stage[k];
    end

    assign sig_o = stage[SHAMT_W];

endmodule

// File: rtl/d2s_narrow.sv
module d2s_narrow
    import d2s_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DBL_W-1:0]  in_dword,
    output logic              out_valid,
    output logic [SGL_W-1:0]  out_word
);

    // field split (vector bit 63 = big-endian bit 0)
    logic                  in_sign;
    logic [DBL_EXP_W-1:0]  in_exp;
    logic [DBL_FRAC_W-1:0] in_frac;
    logic                  mag_zero;

    assign in_sign  = in_dword[DBL_W-1];
    assign in_exp   = in_dword[DBL_W-2 -: DBL_EXP_W];
    assign in_frac  = in_dword[DBL_FRAC_W-1:0];
    assign mag_zero = (in_dword[DBL_W-2:0] == '0);

    path_e              path;
    logic [SHAMT_W-1:0] shamt;
    logic [KEEP_W-1:0]  shifted;
    logic [SGL_W-1:0]   next_word;

    d2s_classify u_classify (
        .exp_i      (in_exp),
        .mag_zero_i (mag_zero),
        .path_o     (path),
        .shamt_o    (shamt)
    );

    d2s_denorm_shift u_shift (
        .sig_i (ensure_hidden(in_frac)),
        .amt_i (shamt),
        .sig_o (shifted)
    );

    function automatic logic [KEEP_W-1:0] ensure_hidden(input logic [DBL_FRAC_W-1:0] f);
        return {1'b1, f[DBL_FRAC_W-1 -: SGL_FRAC_W]};
    endfunction

    // result selection per path
    always_comb begin
        unique case (path)
            PATH_DIRECT:  next_word = {in_sign,
                                       in_exp[DBL_EXP_W-1],
                                       in_exp[DBL_EXP_W-EXP_SKIP_W-2:0],
                                       in_frac[DBL_FRAC_W-1 -: SGL_FRAC_W]};
            PATH_SUBNORM: next_word = {in_sign, {SGL_EXP_W{1'b0}},
                                       shifted[SGL_FRAC_W-1:0]};
            default:      next_word = '0;
        endcase
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word <= next_word;
            end
        end
    end

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_word));

    // R5
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mag_zero && (int'(in_exp) < SUB_MIN_EXP)) |=> (out_word == '0));

    // R3
    subnorm_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (int'(in_exp) >= SUB_MIN_EXP) && (int'(in_exp) < DIRECT_MIN_EXP))
        |=> ((out_word[SGL_W-2 -: SGL_EXP_W] == '0) && (out_word[SGL_FRAC_W-1:0] != '0)
             && (out_word[SGL_W-1] == $past(in_sign))));

    // R3
    hidden_gone_chk: assert property (@(posedge clk) disable iff (rst)
        (path == PATH_SUBNORM) |-> !shifted[KEEP_W-1]);

    // R4
    low_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (int'(in_exp) == SUB_MIN_EXP)) |=> (out_word[SGL_FRAC_W-1:0] == 1));

    // R1
    direct_top_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (int'(in_exp) >= DIRECT_MIN_EXP))
        |=> (out_word[SGL_W-1 -: 2] == $past(in_dword[DBL_W-1 -: 2])));

    // R6
    trunc_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && $past(in_valid) && (in_exp != '0)
         && (in_dword[DBL_W-1:DROP_W] == $past(in_dword[DBL_W-1:DROP_W]))
         && (in_dword[DROP_W-1:0] != $past(in_dword[DROP_W-1:0])))
        |=> $stable(out_word));

endmodule

// File: tb/tb_d2s_narrow.sv
module tb_d2s_narrow;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_dword = '0;
    logic        out_valid;
    logic [31:0] out_word;

    int n_cmp = 0;
    int n_bad = 0;

    logic        ref_v = 1'b0;
    logic [31:0] ref_w = '0;
    string       ref_tag = "R10";

    always #2 clk = ~clk;

    d2s_narrow dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_dword  (in_dword),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    // behavioural reference: iterative denormalisation
    function automatic logic [31:0] ref_conv(input logic [63:0] d);
        int e;
        int x;
        logic [52:0] sig;
        e = int'(d[62:52]);
        if (e > 896 || d[62:0] == 0) return {d[63:62], d[58:29]};
        if (e >= 874 && e <= 896) begin
            sig = {1'b1, d[51:0]};
            x = e - 1023;
            while (x < -126) begin
                sig = {1'b0, sig[52:1]};
                x = x + 1;
            end
            return {d[63], 8'h00, sig[51:29]};
        end
        return 32'h0;
    endfunction

    function automatic string tag_of(input logic [63:0] d);
        int e;
        e = int'(d[62:52]);
        if (d[62:0] == 0) return "R2";
        if (e == 2047) return "R7";
        if (e == 874 || e == 896) return "R4";
        if (e >= 874 && e < 897) return "R3";
        if (e < 874) return "R5";
        return "R1";
    endfunction

    function automatic logic [63:0] mk(input bit s, input int e, input logic [51:0] f);
        return {s, 11'(e), f};
    endfunction

    // compare at negedge, then drive the next beat
    task automatic step(input bit r, input bit v, input logic [63:0] d, input string t);
        @(negedge clk);
        n_cmp++;
        if (out_valid !== ref_v || (ref_v && out_word !== ref_w) ||
            (!ref_v && out_word !== ref_w)) begin
            n_bad++;
            $display("FAIL %s: valid=%0b word=%08h expected valid=%0b word=%08h",
                     ref_tag, out_valid, out_word, ref_v, ref_w);
        end
        rst      = r;
        in_valid = v;
        in_dword = d;
        if (r) begin
            ref_v = 1'b0; ref_w = '0; ref_tag = "R10";
        end else begin
            ref_v = v;
            if (v) begin
                ref_w = ref_conv(d);
                ref_tag = (t != "") ? t : tag_of(d);
            end else begin
                ref_tag = (t != "") ? t : "R9";
            end
        end
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        step(1, 0, '0, "R10");                              // reset state
        step(0, 1, mk(0, 1023, 52'h0), "R1");               // 1.0
        step(0, 1, mk(1, 1024, 52'h4_0000_0000_0000), "R1");// -2.5
        step(0, 0, '0, "R8");                               // idle: valid drops
        step(0, 0, 64'hDEAD_BEEF_0123_4567, "R9");          // ignored data, hold
        step(0, 1, 64'h0, "R2");                            // +0
        step(0, 1, 64'h8000_0000_0000_0000, "R2");          // -0
        step(0, 1, mk(0, 2047, 52'h0), "R7");               // +inf
        step(0, 1, mk(1, 2047, 52'h0), "R7");               // -inf
        step(0, 1, mk(0, 2047, 52'h8_0000_0000_0000), "R7");// qNaN
        step(0, 1, mk(0, 2047, 52'h0_0000_0000_0001), "R7");// payload only in dropped bits
        step(0, 1, mk(0, 897, 52'hF_FFFF_FFFF_FFFF), "R6"); // smallest normal, no rounding
        step(0, 1, mk(1, 896, 52'hA_BCDE_F012_3456), "R4");
        step(0, 1, mk(0, 885, 52'h5_5555_5555_5555), "R3");
        step(0, 1, mk(1, 874, 52'hF_FFFF_FFFF_FFFF), "R4");
        step(0, 1, mk(0, 873, 52'hF_FFFF_FFFF_FFFF), "R5");
        step(0, 1, mk(1, 0, 52'h0_0000_0000_0001), "R5");   // double denormal
        step(0, 1, mk(0, 1, 52'h0), "R5");
        step(0, 1, mk(0, 1200, 52'h1_2345_6789_ABCD), "R1");
        // dropped-bit change on back-to-back beats
        step(0, 1, mk(0, 890, 52'h3_3333_3000_0000), "R6");
        step(0, 1, mk(0, 890, 52'h3_3333_3FFF_FFFF), "R6");
        step(0, 1, mk(0, 1050, 52'h7_0000_0000_0001), "R6");
        step(0, 1, mk(0, 1050, 52'h7_0000_1FFF_FFFF), "R6");
        // reset and a valid beat in the same cycle
        step(1, 1, mk(0, 880, 52'hF_0000_0000_0000), "R10");
        step(0, 0, '0, "R10");
        // random patterns, exponent steered around the window
        for (int i = 0; i < 400; i++) begin
            int e;
            logic [63:0] d;
            case ($urandom % 4)
                0: e = 870 + int'($urandom % 32);
                1: e = int'($urandom % 2048);
                2: e = 2047;
                default: e = 1023 + int'($urandom % 64) - 32;
            endcase
            d = mk(1'($urandom), e, {20'($urandom), 32'($urandom)});
            step(0, 1'(($urandom % 5) != 0), d, "");
        end
        step(0, 0, '0, "R8");
        step(0, 0, '0, "R9");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule